// File: doc/BRIEF.md
# Serial Shift Unit with Selectable Clock Source

This block is an 8-bit serial shift register with a 4-bit edge counter. On every data clock the register moves one place toward its MSB and takes the serial input into bit 0. The register MSB drives the serial output. The data clock comes from one of three sources, picked by a two-bit selector:

- a software strobe;
- a timer compare-match pulse;
- an external serial clock pin.

In the external setting a held control bit picks the clock. When the bit is 0, the pin clocks the block. When the bit is 1, a software toggle strobe clocks it. Each pulse on the toggle strobe flips an internal clock level.

With an external clock, the register samples on the rising edge and the serial output changes only on the falling edge. With the strobe or timer source, the output follows the register MSB at once. The counter counts both edges of the serial clock in the external setting, and one step per event otherwise. When it wraps, it sets a sticky overflow flag. A write port loads the register and the counter directly.

Top module: `serial_shift_unit`

## Requirements
- R1: After reset, shift_o, cnt_o, ovf_o and data_o are all 0.
- R2: With clk_sel_i = 00, a clk_bit_wr_i pulse while clk_bit_i = 1 does three things: it shifts shift_o left by one, loads the synchronized data_i into bit 0, and adds 1 to cnt_o. A pulse while clk_bit_i = 0, or a timer_match_i pulse, changes nothing.
- R3: With clk_sel_i = 01, each timer_match_i pulse shifts and counts as in R2, and clk_bit_wr_i pulses are ignored.
- R4: With clk_sel_i[1] = 1 and clk_bit_i = 0, ext_sck_i drives the block. A rising edge of ext_sck_i shifts the register and adds 1 to the count. A falling edge only adds 1 to the count. Both results show 3 clock cycles after the pin changes.
- R5: With clk_sel_i[1] = 1 and clk_bit_i = 1, each toggle_i pulse makes one edge, starting with a rising one. A rising edge shifts and counts. A falling edge counts. In this setting ext_sck_i has no effect.
- R6: With clk_sel_i[1] = 1, a clk_bit_wr_i pulse does not clock the register or the counter.
- R7: With clk_sel_i[1] = 1, data_o takes the register MSB only on a falling clock edge. It holds its value across rising edges and across direct register writes.
- R8: With clk_sel_i[1] = 0, data_o equals shift_o[7].
- R9: When cnt_o wraps from 15 to 0 on a clock event, ovf_o becomes 1 and stays 1 until cleared.
- R10: An ovf_clr_i pulse clears ovf_o. If a wrap occurs in the same cycle, ovf_o is set instead.
- R11: A wr_shift_i pulse loads wr_shift_data_i, and a wr_cnt_i pulse loads wr_cnt_data_i. A load in the same cycle as a clock event wins over the shift or count step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| clk_sel_i | input | 2 | Clock source: 00 strobe, 01 timer, 1x external |
| clk_bit_i | input | 1 | Strobe value; in the external setting, 1 selects toggle clocking |
| clk_bit_wr_i | input | 1 | Write pulse for clk_bit_i |
| timer_match_i | input | 1 | Timer compare-match pulse |
| toggle_i | input | 1 | Toggle strobe for software external clocking |
| ext_sck_i | input | 1 | Asynchronous external serial clock |
| data_i | input | 1 | Asynchronous serial data input |
| wr_shift_i | input | 1 | Load pulse for the shift register |
| wr_shift_data_i | input | 8 | Shift register load value |
| wr_cnt_i | input | 1 | Load pulse for the counter |
| wr_cnt_data_i | input | 4 | Counter load value |
| ovf_clr_i | input | 1 | Overflow clear pulse |
| shift_o | output | 8 | Shift register contents |
| cnt_o | output | 4 | Counter value |
| ovf_o | output | 1 | Sticky overflow flag |
| data_o | output | 1 | Serial data output |

## Verification
Results of strobe, timer, toggle and load pulses are registered once, so they are due at the first rising edge after the pulse. The bench drives each pulse for one cycle from a falling edge and samples at the next falling edge.

The external pin passes through two synchronizer flops and one edge-detect flop before the register updates, so pin results are due 3 cycles after the change. The bench waits exactly 3 cycles before it checks. Serial data is set at least 3 cycles before each clock event so that the synchronized value is settled.

// File: rtl/ssu_pkg.sv
package ssu_pkg;
  typedef enum logic [1:0] {
    SRC_SOFT  = 2'b00,
    SRC_TIMER = 2'b01,
    SRC_EXT   = 2'b10,
    SRC_EXT2  = 2'b11
  } clk_src_e;
endpackage

// File: rtl/ssu_sync.sv
module ssu_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[i] <= '0;
      else if (i == 0) stg_q[i] <= d_i;
      else stg_q[i] <= stg_q[(i > 0) ? i - 1 : 0];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/ssu_clk_sel.sv
module ssu_clk_sel
  import ssu_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] clk_sel_i,
  input  logic       clk_bit_i,
  input  logic       clk_bit_wr_i,
  input  logic       timer_match_i,
  input  logic       toggle_i,
  input  logic       sck_sync_i,
  output logic       shift_ev_o,
  output logic       cnt_ev_o,
  output logic       do_ev_o,
  output logic       ext_o
);
  clk_src_e src;
  logic sck_prev_q, tgl_q;
  logic pin_rise, pin_fall, tgl_rise, tgl_fall, rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_prev_q <= 1'b0;
      tgl_q      <= 1'b0;
    end else begin
      sck_prev_q <= sck_sync_i;
      if (toggle_i) tgl_q <= ~tgl_q;
    end
  end

  always_comb begin
    src      = clk_src_e'(clk_sel_i);
    pin_rise = sck_sync_i & ~sck_prev_q;
    pin_fall = ~sck_sync_i & sck_prev_q;
    tgl_rise = toggle_i & ~tgl_q;
    tgl_fall = toggle_i & tgl_q;
    rise     = clk_bit_i ? tgl_rise : pin_rise;
    fall     = clk_bit_i ? tgl_fall : pin_fall;
    ext_o    = 1'b0;
    do_ev_o  = 1'b0;
    unique case (src)
      SRC_SOFT: begin
        shift_ev_o = clk_bit_wr_i & clk_bit_i;
        cnt_ev_o   = clk_bit_wr_i & clk_bit_i;
      end
      SRC_TIMER: begin
        shift_ev_o = timer_match_i;
        cnt_ev_o   = timer_match_i;
      end
      default: begin
        // Sample on the rising edge, count both edges, drive out on the falling edge
        ext_o      = 1'b1;
        shift_ev_o = rise;
        cnt_ev_o   = rise | fall;
        do_ev_o    = fall;
      end
    endcase
  end
endmodule

// File: rtl/ssu_datapath.sv
module ssu_datapath #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_ev_i,
  input  logic              cnt_ev_i,
  input  logic              do_ev_i,
  input  logic              ext_i,
  input  logic              din_i,
  input  logic              wr_shift_i,
  input  logic [DATA_W-1:0] wr_shift_data_i,
  input  logic              wr_cnt_i,
  input  logic [CNT_W-1:0]  wr_cnt_data_i,
  input  logic              ovf_clr_i,
  output logic [DATA_W-1:0] shift_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              ovf_o,
  output logic              data_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [DATA_W-1:0] shift_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              ovf_q, do_q, wrap;

  assign wrap = cnt_ev_i & ~wr_cnt_i & (cnt_q == CNT_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_q <= '0;
      cnt_q   <= '0;
      ovf_q   <= 1'b0;
      do_q    <= 1'b0;
    end else begin
      if (wr_shift_i)      shift_q <= wr_shift_data_i;
      else if (shift_ev_i) shift_q <= {shift_q[DATA_W-2:0], din_i};

      if (wr_cnt_i)      cnt_q <= wr_cnt_data_i;
      else if (cnt_ev_i) cnt_q <= cnt_q + 1'b1;

      if (wrap)           ovf_q <= 1'b1;
      else if (ovf_clr_i) ovf_q <= 1'b0;

      // Output latch: retimed for external clocking, tracks MSB otherwise
      if (!ext_i || do_ev_i) do_q <= shift_q[DATA_W-1];
    end
  end

  assign shift_o = shift_q;
  assign cnt_o   = cnt_q;
  assign ovf_o   = ovf_q;
  assign data_o  = ext_i ? do_q : shift_q[DATA_W-1];
endmodule

// File: rtl/serial_shift_unit.sv
module serial_shift_unit #(
  parameter int DATA_W      = 8,
  parameter int CNT_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        clk_sel_i,
  input  logic              clk_bit_i,
  input  logic              clk_bit_wr_i,
  input  logic              timer_match_i,
  input  logic              toggle_i,
  input  logic              ext_sck_i,
  input  logic              data_i,
  input  logic              wr_shift_i,
  input  logic [DATA_W-1:0] wr_shift_data_i,
  input  logic              wr_cnt_i,
  input  logic [CNT_W-1:0]  wr_cnt_data_i,
  input  logic              ovf_clr_i,
  output logic [DATA_W-1:0] shift_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              ovf_o,
  output logic              data_o
);
  logic [1:0] sync_q;
  logic       shift_ev, cnt_ev, do_ev, ext;

  // Clock and data share one synchronizer so they stay aligned
  ssu_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({ext_sck_i, data_i}),
    .q_o    (sync_q)
  );

  ssu_clk_sel u_clk_sel (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .clk_sel_i     (clk_sel_i),
    .clk_bit_i     (clk_bit_i),
    .clk_bit_wr_i  (clk_bit_wr_i),
    .timer_match_i (timer_match_i),
    .toggle_i      (toggle_i),
    .sck_sync_i    (sync_q[1]),
    .shift_ev_o    (shift_ev),
    .cnt_ev_o      (cnt_ev),
    .do_ev_o       (do_ev),
    .ext_o         (ext)
  );

  ssu_datapath #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_datapath (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .shift_ev_i      (shift_ev),
    .cnt_ev_i        (cnt_ev),
    .do_ev_i         (do_ev),
    .ext_i           (ext),
    .din_i           (sync_q[0]),
    .wr_shift_i      (wr_shift_i),
    .wr_shift_data_i (wr_shift_data_i),
    .wr_cnt_i        (wr_cnt_i),
    .wr_cnt_data_i   (wr_cnt_data_i),
    .ovf_clr_i       (ovf_clr_i),
    .shift_o         (shift_o),
    .cnt_o           (cnt_o),
    .ovf_o           (ovf_o),
    .data_o          (data_o)
  );
endmodule

// File: rtl/serial_shift_unit_chk.sv
module serial_shift_unit_chk #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [1:0]        clk_sel_i,
  input logic              clk_bit_wr_i,
  input logic              timer_match_i,
  input logic              wr_shift_i,
  input logic [DATA_W-1:0] wr_shift_data_i,
  input logic              wr_cnt_i,
  input logic [CNT_W-1:0]  wr_cnt_data_i,
  input logic              ovf_clr_i,
  input logic [DATA_W-1:0] shift_o,
  input logic [CNT_W-1:0]  cnt_o,
  input logic              ovf_o,
  input logic              data_o
);
  // R2
  soft_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_sel_i == 2'b00 && !clk_bit_wr_i && !wr_shift_i) |=> $stable(shift_o));

  // R3
  timer_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_sel_i == 2'b01 && !timer_match_i && !wr_shift_i) |=> $stable(shift_o));

  // R8
  transparent_do_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clk_sel_i[1] |-> data_o == shift_o[DATA_W-1]);

  // R9
  wrap_sets_ovf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o == '0 && $past(cnt_o) == {CNT_W{1'b1}} && !$past(wr_cnt_i)) |-> ovf_o);

  // R10
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !ovf_clr_i) |=> ovf_o);

  // R11
  cnt_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cnt_i |=> cnt_o == $past(wr_cnt_data_i));

  // R11
  shift_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_shift_i |=> shift_o == $past(wr_shift_data_i));
endmodule

bind serial_shift_unit serial_shift_unit_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .clk_sel_i       (clk_sel_i),
  .clk_bit_wr_i    (clk_bit_wr_i),
  .timer_match_i   (timer_match_i),
  .wr_shift_i      (wr_shift_i),
  .wr_shift_data_i (wr_shift_data_i),
  .wr_cnt_i        (wr_cnt_i),
  .wr_cnt_data_i   (wr_cnt_data_i),
  .ovf_clr_i       (ovf_clr_i),
  .shift_o         (shift_o),
  .cnt_o           (cnt_o),
  .ovf_o           (ovf_o),
  .data_o          (data_o)
);

// File: tb/serial_shift_unit_bench.sv
module serial_shift_unit_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] clk_sel = 2'b00;
  logic       clk_bit = 1'b0, clk_bit_wr = 1'b0, timer_match = 1'b0, toggle = 1'b0;
  logic       ext_sck = 1'b0, din = 1'b0;
  logic       wr_shift = 1'b0, wr_cnt = 1'b0, ovf_clr = 1'b0;
  logic [7:0] wr_shift_data = '0;
  logic [3:0] wr_cnt_data = '0;
  logic [7:0] shift;
  logic [3:0] cnt;
  logic       ovf, dout;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  serial_shift_unit u_serial_shift_unit (
    .clk_i (clk), .rst_ni (rst_n), .clk_sel_i (clk_sel), .clk_bit_i (clk_bit),
    .clk_bit_wr_i (clk_bit_wr), .timer_match_i (timer_match), .toggle_i (toggle),
    .ext_sck_i (ext_sck), .data_i (din), .wr_shift_i (wr_shift),
    .wr_shift_data_i (wr_shift_data), .wr_cnt_i (wr_cnt), .wr_cnt_data_i (wr_cnt_data),
    .ovf_clr_i (ovf_clr), .shift_o (shift), .cnt_o (cnt), .ovf_o (ovf), .data_o (dout)
  );

  // {mode[1:0], kind[1:0], din, shift[7:0], cnt[3:0]}; kind 0 strobe=1, 1 strobe=0, 2 timer
  localparam logic [16:0] VEC [8] = '{
    {2'b00, 2'd0, 1'b1, 8'h4B, 4'd1},
    {2'b00, 2'd1, 1'b0, 8'h4B, 4'd1},
    {2'b00, 2'd2, 1'b0, 8'h4B, 4'd1},
    {2'b01, 2'd2, 1'b0, 8'h96, 4'd2},
    {2'b01, 2'd0, 1'b1, 8'h96, 4'd2},
    {2'b01, 2'd2, 1'b1, 8'h2D, 4'd3},
    {2'b00, 2'd0, 1'b1, 8'h5B, 4'd4},
    {2'b00, 2'd0, 1'b0, 8'hB6, 4'd5}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe();
    clk_bit_wr = 1'b1; @(negedge clk); clk_bit_wr = 1'b0;
  endtask

  task automatic tmr();
    timer_match = 1'b1; @(negedge clk); timer_match = 1'b0;
  endtask

  task automatic tgl();
    toggle = 1'b1; @(negedge clk); toggle = 1'b0;
  endtask

  task automatic load(input logic ds, input logic [7:0] sv, input logic dc, input logic [3:0] cv);
    wr_shift = ds; wr_shift_data = sv; wr_cnt = dc; wr_cnt_data = cv;
    @(negedge clk);
    wr_shift = 1'b0; wr_cnt = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    cyc(3);
    // R1 reset state
    chk("R1 shift", shift, 8'h00);
    chk("R1 cnt", {4'h0, cnt}, 8'h00);
    chk("R1 ovf", {7'h0, ovf}, 8'h00);
    chk("R1 data_o", {7'h0, dout}, 8'h00);
    rst_n = 1'b1;
    cyc(2);

    load(1'b1, 8'hA5, 1'b1, 4'd0);
    chk("R11 shift load", shift, 8'hA5);

    // R2 R3 R8: strobe and timer sources from table
    for (int i = 0; i < 8; i++) begin
      logic [16:0] v;
      v = VEC[i];
      clk_sel = v[16:15];
      din = v[12];
      cyc(3);
      case (v[14:13])
        2'd0: begin clk_bit = 1'b1; strobe(); end
        2'd1: begin clk_bit = 1'b0; strobe(); end
        default: tmr();
      endcase
      chk(v[16:15] == 2'b00 ? "R2 shift" : "R3 shift", shift, v[11:4]);
      chk(v[16:15] == 2'b00 ? "R2 cnt" : "R3 cnt", {4'h0, cnt}, {4'h0, v[3:0]});
      chk("R8 data_o", {7'h0, dout}, {7'h0, v[11]});
    end

    // R4 R7: external pin
    clk_sel = 2'b00;
    load(1'b1, 8'h81, 1'b1, 4'd0);
    cyc(2);
    clk_sel = 2'b10; clk_bit = 1'b0; din = 1'b0;
    cyc(3);
    ext_sck = 1'b1; cyc(3);
    chk("R4 rise shift", shift, 8'h02);
    chk("R4 rise cnt", {4'h0, cnt}, 8'd1);
    chk("R7 hold on rise", {7'h0, dout}, 8'd1);
    ext_sck = 1'b0; cyc(3);
    chk("R4 fall cnt", {4'h0, cnt}, 8'd2);
    chk("R4 fall shift", shift, 8'h02);
    chk("R7 update on fall", {7'h0, dout}, 8'd0);
    din = 1'b1; cyc(3);
    ext_sck = 1'b1; cyc(3);
    chk("R4 rise2 shift", shift, 8'h05);
    ext_sck = 1'b0; cyc(3);
    chk("R4 fall2 cnt", {4'h0, cnt}, 8'd4);

    // R6: strobe does not clock in external setting
    clk_bit = 1'b0; strobe(); cyc(1);
    chk("R6 shift", shift, 8'h05);
    chk("R6 cnt", {4'h0, cnt}, 8'd4);

    // R7 R11: direct write does not move data_o
    load(1'b1, 8'h40, 1'b0, 4'd0);
    chk("R11 ext load", shift, 8'h40);
    chk("R7 hold on load", {7'h0, dout}, 8'd0);

    // R5: toggle clocking, pin ignored
    clk_bit = 1'b1; cyc(1);
    tgl();
    chk("R5 rise shift", shift, 8'h81);
    chk("R5 rise cnt", {4'h0, cnt}, 8'd5);
    chk("R7 hold toggle rise", {7'h0, dout}, 8'd0);
    ext_sck = 1'b1; cyc(4);
    chk("R5 pin ignored shift", shift, 8'h81);
    chk("R5 pin ignored cnt", {4'h0, cnt}, 8'd5);
    tgl();
    chk("R5 fall cnt", {4'h0, cnt}, 8'd6);
    chk("R7 toggle fall", {7'h0, dout}, 8'd1);
    ext_sck = 1'b0;
    clk_sel = 2'b00; cyc(4);

    // R9 R10: overflow
    clk_bit = 1'b1;
    load(1'b0, 8'h00, 1'b1, 4'd14);
    strobe();
    chk("R9 cnt 15", {4'h0, cnt}, 8'd15);
    chk("R9 no ovf yet", {7'h0, ovf}, 8'd0);
    strobe();
    chk("R9 wrap cnt", {4'h0, cnt}, 8'd0);
    chk("R9 ovf set", {7'h0, ovf}, 8'd1);
    strobe();
    chk("R9 ovf sticky", {7'h0, ovf}, 8'd1);
    ovf_clr = 1'b1; @(negedge clk); ovf_clr = 1'b0;
    chk("R10 clear", {7'h0, ovf}, 8'd0);
    load(1'b0, 8'h00, 1'b1, 4'd15);
    ovf_clr = 1'b1; clk_bit_wr = 1'b1; @(negedge clk);
    ovf_clr = 1'b0; clk_bit_wr = 1'b0;
    chk("R10 set wins", {7'h0, ovf}, 8'd1);
    chk("R10 wrap cnt", {4'h0, cnt}, 8'd0);

    // R11: load wins over clock event
    wr_cnt = 1'b1; wr_cnt_data = 4'd3; clk_bit_wr = 1'b1; @(negedge clk);
    wr_cnt = 1'b0; clk_bit_wr = 1'b0;
    chk("R11 cnt priority", {4'h0, cnt}, 8'd3);
    wr_shift = 1'b1; wr_shift_data = 8'h3C; clk_bit_wr = 1'b1; @(negedge clk);
    wr_shift = 1'b0; clk_bit_wr = 1'b0;
    chk("R11 shift priority", shift, 8'h3C);
    chk("R8 after load", {7'h0, dout}, 8'd0);

    finish_run();
  end
endmodule